// File: doc/BRIEF.md
# Dual-Channel Indirect Register File

This block is the host-facing register unit of a two-channel serial controller. Each channel has a byte-wide control port and a byte-wide data port on a shared bus. The data port goes straight to the channel's receive and transmit data. The control port reaches sixteen write registers and a set of read registers through a per-channel pointer.

When a channel's pointer is zero, a control-port write is treated as a register-0 write. That byte carries three things: the number of the next register, a command code and a reset code. The next control-port access, read or write, reaches the selected register and sets the pointer back to zero. Registers 8 to 15 can only be selected when the point-high command is in the same byte.

The interrupt vector register (2) and the master interrupt control register (9) are shared by both channels. Register 9 also carries channel and hardware reset codes. The read side combines status arriving from the serial engines with stored configuration. That includes a combined interrupt-pending register, which exists on channel A only, and a vector read that can have an interrupt status code inserted into it.

Top module: `sio_regfile`

## Requirements
- R1: A data-port access (`bus_data`=1) goes only to the addressed channel. A write raises `dat_wr[ch]` in the same cycle. A read raises `dat_rd[ch]` and returns `rxd_a`/`rxd_b` on `bus_rdata`. Neither access changes that channel's pointer.
- R2: A control write with the pointer at zero loads the pointer with the value of bits 2:0. If bits 5:3 equal 001 (byte value 0x08, point high), 8 is added. Without point high, registers 8–15 cannot be selected.
- R3: With the pointer non-zero, a control write stores the byte in the selected register. A control read returns the selected read register. Either access sets the pointer back to 0, so the next control write is again a register-0 write. A byte written to a selected register is never decoded as a command.
- R4: In a register-0 write, command codes 2–7 in bits 5:3 pulse `cmd_stb[ch]` for one cycle, starting the cycle after the write, with `cmd_code` equal to the code. Code 0 (null) and code 1 (point high) give no pulse. Code 2 resets external/status, 3 sends abort, 4 enables interrupt on the next received character, 5 resets transmit pending, 6 resets errors and 7 resets the highest interrupt under service.
- R5: In a register-0 write, a non-zero reset code in bits 7:6 pulses `crc_stb[ch]` for one cycle, starting the cycle after the write, with `crc_code` equal to the code. Code 1 resets the receive CRC checker, 2 resets the transmit CRC generator and 3 resets the transmit underrun/end-of-message latch. This reset pulse and a command pulse can come from the same byte.
- R6: Registers 2 and 9 are shared. A write through either channel appears in slot 2 or slot 9 of both `cfg_a` and `cfg_b`. A channel reset leaves both shared registers unchanged.
- R7: Read register 3 on channel A returns {2'b00, ip_a, ip_b}, where each `ip` is {rx, tx, status} pending. On channel B the same register reads 0x00.
- R8: Read register 2 on channel A returns the stored vector. On channel B it returns the stored vector unchanged while register 9 bit 0 is clear. When bit 0 is set, a 3-bit status code replaces vector bits 3:1 if register 9 bit 4 is clear, or bits 6:4 if it is set. The code is that of the highest pending source, in the order A rx=110, A tx=100, A status=101, B rx=010, B tx=000, B status=001; with nothing pending the code is 011.
- R9: Read registers map as follows: 0 returns `st0_x`, 1 returns `st1_x`, 8 returns `rxd_x`, 10 returns `misc_x`, and 12 and 13 return write registers 12 and 13. Register 15 returns write register 15 with bits 2 and 0 forced to 0. Registers 4–7, 9, 11 and 14 read 0x00.
- R10: A register-9 write with bits 7:6 = 11 clears every write register and both pointers and pulses `chan_rst`=11. With 10 it clears only channel A's non-shared registers and pointer and pulses `chan_rst[0]`. With 01 it does the same for channel B and pulses `chan_rst[1]`. The pulse appears the cycle after the write. Otherwise register 9 stores bits 5:0, with bits 7:6 stored as 0.
- R11: While `rst_n` is low, all write registers, pointers and pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ch | input | 1 | Channel select: 0 = A, 1 = B |
| bus_data | input | 1 | 1 = data port, 0 = control port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational, 0 when not reading) |
| st0_a | input | 8 | Channel A buffer/external status |
| st0_b | input | 8 | Channel B buffer/external status |
| st1_a | input | 8 | Channel A special receive status |
| st1_b | input | 8 | Channel B special receive status |
| misc_a | input | 8 | Channel A miscellaneous status |
| misc_b | input | 8 | Channel B miscellaneous status |
| rxd_a | input | 8 | Channel A received byte |
| rxd_b | input | 8 | Channel B received byte |
| ip_a | input | 3 | Channel A pending {rx, tx, status} |
| ip_b | input | 3 | Channel B pending {rx, tx, status} |
| dat_wr | output | 2 | Data-port write strobe per channel |
| dat_rd | output | 2 | Data-port read strobe per channel |
| cfg_a | output | 128 | Channel A write registers, slot n at bits 8n+7:8n |
| cfg_b | output | 128 | Channel B write registers, same layout |
| cmd_stb | output | 2 | Command pulse per channel |
| cmd_code | output | 3 | Code of the last command |
| crc_stb | output | 2 | Reset-code pulse per channel |
| crc_code | output | 2 | Code of the last reset code |
| chan_rst | output | 2 | Reset pulse: bit 0 = A, bit 1 = B |

## Verification
The bench writes bytes that look like commands (0x38) into a selected register. A design that decoded every control write as a command would pulse `cmd_stb` and lose the data. The bench selects a register on one channel and then resets that channel from the other channel. A design that kept the stale pointer would store the next register-0 byte as data. It also checks that 0x08 with no register bits selects register 8, that point high alone gives no command pulse, and that a channel reset leaves the shared vector and its neighbour's registers alone. Finally it steps the vector-with-status read through both placements, several priority combinations and the nothing-pending code, which catches a wrong priority order or field position.

// File: rtl/sio_regfile.sv
module sio_regfile (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_ch,
  input  logic         bus_data,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic [7:0]   st0_a,
  input  logic [7:0]   st0_b,
  input  logic [7:0]   st1_a,
  input  logic [7:0]   st1_b,
  input  logic [7:0]   misc_a,
  input  logic [7:0]   misc_b,
  input  logic [7:0]   rxd_a,
  input  logic [7:0]   rxd_b,
  input  logic [2:0]   ip_a,
  input  logic [2:0]   ip_b,
  output logic [1:0]   dat_wr,
  output logic [1:0]   dat_rd,
  output logic [127:0] cfg_a,
  output logic [127:0] cfg_b,
  output logic [1:0]   cmd_stb,
  output logic [2:0]   cmd_code,
  output logic [1:0]   crc_stb,
  output logic [1:0]   crc_code,
  output logic [1:0]   chan_rst
);

  localparam logic [3:0] SLOT_VEC = 4'd2;
  localparam logic [3:0] SLOT_MIC = 4'd9;

  logic [3:0] ptr  [2];
  logic [7:0] wreg [2][16];

  logic [1:0] ch_oh;
  assign ch_oh = bus_ch ? 2'b10 : 2'b01;

  logic ctl_wr, ctl_rd;
  assign ctl_wr = bus_wr & ~bus_data;
  assign ctl_rd = bus_rd & ~bus_data;
  assign dat_wr = (bus_wr & bus_data) ? ch_oh : 2'b00;
  assign dat_rd = (bus_rd & bus_data) ? ch_oh : 2'b00;

  logic [3:0] cur_ptr;
  assign cur_ptr = ptr[bus_ch];

  logic sel_wr, reg_wr, wr9;
  logic [2:0] wcmd;
  logic [1:0] wrst, rst9;
  logic [3:0] new_ptr;
  assign sel_wr  = ctl_wr & (cur_ptr == 4'd0);
  assign reg_wr  = ctl_wr & (cur_ptr != 4'd0);
  assign wcmd    = bus_wdata[5:3];
  assign wrst    = bus_wdata[7:6];
  assign new_ptr = {wcmd == 3'd1, bus_wdata[2:0]};
  assign wr9     = reg_wr & (cur_ptr == SLOT_MIC);
  assign rst9    = wr9 ? bus_wdata[7:6] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        ptr[c] <= '0;
        for (int i = 0; i < 16; i++) wreg[c][i] <= '0;
      end
      cmd_stb  <= '0;
      cmd_code <= '0;
      crc_stb  <= '0;
      crc_code <= '0;
      chan_rst <= '0;
    end else begin
      cmd_stb  <= '0;
      crc_stb  <= '0;
      chan_rst <= {rst9[0], rst9[1]};
      if (sel_wr) begin
        ptr[bus_ch] <= new_ptr;
        cmd_code    <= wcmd;
        crc_code    <= wrst;
        if (wcmd >= 3'd2) cmd_stb <= ch_oh;
        if (wrst != 2'd0) crc_stb <= ch_oh;
      end
      if (reg_wr) begin
        ptr[bus_ch] <= '0;
        if (cur_ptr == SLOT_VEC) begin
          wreg[0][SLOT_VEC] <= bus_wdata;
          wreg[1][SLOT_VEC] <= bus_wdata;
        end else if (cur_ptr == SLOT_MIC) begin
          wreg[0][SLOT_MIC] <= {2'b00, bus_wdata[5:0]};
          wreg[1][SLOT_MIC] <= {2'b00, bus_wdata[5:0]};
        end else begin
          wreg[bus_ch][cur_ptr] <= bus_wdata;
        end
      end
      if (ctl_rd) ptr[bus_ch] <= '0;
      for (int c = 0; c < 2; c++) begin
        if (rst9 == 2'b11 || (c == 0 && rst9 == 2'b10) || (c == 1 && rst9 == 2'b01)) begin
          ptr[c] <= '0;
          for (int i = 0; i < 16; i++)
            if (rst9 == 2'b11 || (i != int'(SLOT_VEC) && i != int'(SLOT_MIC)))
              wreg[c][i] <= '0;
        end
      end
    end
  end

  for (genvar i = 0; i < 16; i++) begin : g_cfg
    assign cfg_a[8*i +: 8] = wreg[0][i];
    assign cfg_b[8*i +: 8] = wreg[1][i];
  end

  logic [7:0] vec, mic;
  logic [2:0] scode;
  assign vec = wreg[0][SLOT_VEC];
  assign mic = wreg[0][SLOT_MIC];

  always_comb begin
    if      (ip_a[2]) scode = 3'b110;
    else if (ip_a[1]) scode = 3'b100;
    else if (ip_a[0]) scode = 3'b101;
    else if (ip_b[2]) scode = 3'b010;
    else if (ip_b[1]) scode = 3'b000;
    else if (ip_b[0]) scode = 3'b001;
    else              scode = 3'b011;
  end

  logic [7:0] vec_b;
  always_comb begin
    if (!mic[0])     vec_b = vec;
    else if (mic[4]) vec_b = {vec[7], scode, vec[3:0]};
    else             vec_b = {vec[7:4], scode, vec[0]};
  end

  logic [7:0] rr;
  always_comb begin
    case (cur_ptr)
      4'd0:    rr = bus_ch ? st0_b : st0_a;
      4'd1:    rr = bus_ch ? st1_b : st1_a;
      4'd2:    rr = bus_ch ? vec_b : vec;
      4'd3:    rr = bus_ch ? 8'h00 : {2'b00, ip_a, ip_b};
      4'd8:    rr = bus_ch ? rxd_b : rxd_a;
      4'd10:   rr = bus_ch ? misc_b : misc_a;
      4'd12:   rr = wreg[bus_ch][12];
      4'd13:   rr = wreg[bus_ch][13];
      4'd15:   rr = wreg[bus_ch][15] & 8'hFA;
      default: rr = 8'h00;
    endcase
  end

  always_comb begin
    if (!bus_rd)       bus_rdata = 8'h00;
    else if (bus_data) bus_rdata = bus_ch ? rxd_b : rxd_a;
    else               bus_rdata = rr;
  end

  AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || ctl_rd) |=> ptr[$past(bus_ch)] == 4'd0); // R3

  AST_HIGH_NEEDS_PH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && wcmd != 3'd1) |=> ptr[$past(bus_ch)] < 4'd8); // R2

  AST_NO_CMD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && wcmd[2:1] == 2'b00) |=> cmd_stb == 2'b00); // R4

  AST_CHAN_A_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr9 && bus_wdata[7]) |=> (ptr[0] == 4'd0 && cfg_a[127:120] == 8'h00)); // R10

  AST_SHARED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr9 && (bus_wdata[7] ^ bus_wdata[6])) |=> vec == $past(vec)); // R6

  AST_SHARED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_a[23:16] == cfg_b[23:16] && cfg_a[79:72] == cfg_b[79:72]); // R6

endmodule

// File: tb/sio_regfile_tb.sv
`timescale 1ns/1ps
module sio_regfile_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic bus_ch = 0, bus_data = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] st0_a = 8'h11, st0_b = 8'h22, st1_a = 8'h33, st1_b = 8'h44;
  logic [7:0] misc_a = 8'h55, misc_b = 8'h66, rxd_a = 8'hC3, rxd_b = 8'h3C;
  logic [2:0] ip_a = 0, ip_b = 0;
  logic [1:0] dat_wr, dat_rd, cmd_stb, crc_stb, crc_code, chan_rst;
  logic [2:0] cmd_code;
  logic [127:0] cfg_a, cfg_b;

  int nchk = 0, nfail = 0;
  bit done = 0;

  sio_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ch(bus_ch), .bus_data(bus_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st0_a(st0_a), .st0_b(st0_b), .st1_a(st1_a), .st1_b(st1_b),
    .misc_a(misc_a), .misc_b(misc_b), .rxd_a(rxd_a), .rxd_b(rxd_b),
    .ip_a(ip_a), .ip_b(ip_b), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .crc_stb(crc_stb), .crc_code(crc_code), .chan_rst(chan_rst)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(logic [127:0] cfg, int n);
    return cfg[8*n +: 8];
  endfunction

  task automatic ctl_wr(logic ch, logic [7:0] v);
    @(negedge clk);
    bus_ch = ch; bus_data = 0; bus_wr = 1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic ctl_rd(logic ch, output logic [7:0] v);
    @(negedge clk);
    bus_ch = ch; bus_data = 0; bus_rd = 1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic sel(logic ch, int n);
    if (n != 0) ctl_wr(ch, (n >= 8) ? 8'(8 | (n & 7)) : 8'(n));
  endtask

  task automatic wreg(logic ch, int n, logic [7:0] v);
    sel(ch, n);
    ctl_wr(ch, v);
  endtask

  task automatic rreg(logic ch, int n, output logic [7:0] v);
    sel(ch, n);
    ctl_rd(ch, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 cfg_a low", cfg_a[63:0] == 0 && cfg_a[127:64] == 0, 1);
    chk("R11 cfg_b", (cfg_b == 0), 1);
    chk("R11 strobes", {cmd_stb, crc_stb, chan_rst}, 0);
    rreg(1, 15, v);
    chk("R11 rr15", v, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] v;
    @(negedge clk);
    bus_ch = 1; bus_data = 1; bus_wr = 1; bus_wdata = 8'h99;
    #1 chk("R1 dat_wr B", dat_wr, 2'b10);
    @(negedge clk);
    bus_wr = 0; bus_ch = 0; bus_rd = 1;
    #1 chk("R1 data read A", bus_rdata, rxd_a);
    chk("R1 dat_rd A", dat_rd, 2'b01);
    @(negedge clk);
    bus_rd = 0;
    sel(0, 12);
    @(negedge clk);
    bus_ch = 0; bus_data = 1; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0; bus_wr = 1; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 0; bus_data = 0;
    ctl_wr(0, 8'h5A);
    chk("R1 ptr kept over data access", slot(cfg_a, 12), 8'h5A);
    chk("R1 data byte not stored", slot(cfg_a, 1), 8'h00);
  endtask

  task automatic t_point();
    wreg(0, 5, 8'h33);
    chk("R2 reg5", slot(cfg_a, 5), 8'h33);
    chk("R2 reg13 untouched", slot(cfg_a, 13), 8'h00);
    wreg(0, 13, 8'h44);
    chk("R2 reg13 point high", slot(cfg_a, 13), 8'h44);
    ctl_wr(0, 8'h08);
    ctl_wr(0, 8'h77);
    chk("R2 0x08 selects reg8", slot(cfg_a, 8), 8'h77);
  endtask

  task automatic t_ptr_return();
    logic [7:0] v;
    rreg(0, 12, v);
    chk("R3 read reg12", v, 8'h5A);
    wreg(0, 7, 8'h99);
    chk("R3 write after read", slot(cfg_a, 7), 8'h99);
    ctl_wr(0, 8'h03);
    ctl_wr(0, 8'h11);
    ctl_wr(0, 8'h04);
    ctl_wr(0, 8'h22);
    chk("R3 reg3", slot(cfg_a, 3), 8'h11);
    chk("R3 reg4 after return", slot(cfg_a, 4), 8'h22);
  endtask

  task automatic t_cmd();
    ctl_wr(0, 8'h28);
    chk("R4 cmd strobe A", cmd_stb, 2'b01);
    chk("R4 cmd code 5", cmd_code, 3'd5);
    ctl_wr(1, 8'h38);
    chk("R4 cmd strobe B", cmd_stb, 2'b10);
    chk("R4 cmd code 7", cmd_code, 3'd7);
    ctl_wr(1, 8'h0B);
    chk("R4 point high no strobe", cmd_stb, 2'b00);
    ctl_wr(1, 8'h38);
    chk("R3 data byte not command", cmd_stb, 2'b00);
    chk("R3 reg11 B stored", slot(cfg_b, 11), 8'h38);
    ctl_wr(0, 8'h00);
    chk("R4 null no strobe", cmd_stb, 2'b00);
  endtask

  task automatic t_crc();
    ctl_wr(0, 8'h40);
    chk("R5 crc strobe A", crc_stb, 2'b01);
    chk("R5 crc code 1", crc_code, 2'd1);
    ctl_wr(1, 8'hC0);
    chk("R5 crc strobe B", crc_stb, 2'b10);
    chk("R5 crc code 3", crc_code, 2'd3);
    ctl_wr(0, 8'h90);
    chk("R5 both crc", {crc_stb, crc_code}, {2'b01, 2'd2});
    chk("R5 both cmd", {3'b0, cmd_stb, cmd_code}, {3'b0, 2'b01, 3'd2});
  endtask

  task automatic t_shared();
    wreg(0, 2, 8'hA5);
    chk("R6 vec via A in B", slot(cfg_b, 2), 8'hA5);
    wreg(1, 9, 8'h15);
    chk("R6 reg9 via B in A", slot(cfg_a, 9), 8'h15);
  endtask

  task automatic t_rr3();
    logic [7:0] v;
    ip_a = 3'b101; ip_b = 3'b010;
    rreg(0, 3, v);
    chk("R7 rr3 A", v, 8'h2A);
    rreg(1, 3, v);
    chk("R7 rr3 B zero", v, 8'h00);
    ip_a = 0; ip_b = 0;
  endtask

  task automatic t_rr2();
    logic [7:0] v;
    ip_b = 3'b010;
    rreg(1, 2, v);
    chk("R8 status high B tx", v, 8'h85);
    rreg(0, 2, v);
    chk("R8 A raw", v, 8'hA5);
    wreg(0, 9, 8'h01);
    ip_b = 3'b001;
    rreg(1, 2, v);
    chk("R8 status low B stat", v, 8'hA3);
    ip_b = 0;
    rreg(1, 2, v);
    chk("R8 none pending", v, 8'hA7);
    ip_a = 3'b100; ip_b = 3'b111;
    rreg(1, 2, v);
    chk("R8 A rx priority", v, 8'hAD);
    ip_a = 3'b011;
    rreg(1, 2, v);
    chk("R8 A tx over A stat", v, 8'hA9);
    wreg(0, 9, 8'h00);
    rreg(1, 2, v);
    chk("R8 B raw without status", v, 8'hA5);
    ip_a = 0; ip_b = 0;
  endtask

  task automatic t_rr_misc();
    logic [7:0] v;
    wreg(0, 15, 8'hFF);
    rreg(0, 15, v);
    chk("R9 rr15 mask", v, 8'hFA);
    rreg(0, 13, v);
    chk("R9 rr13", v, 8'h44);
    rreg(0, 0, v);
    chk("R9 rr0 A", v, st0_a);
    rreg(1, 1, v);
    chk("R9 rr1 B", v, st1_b);
    rreg(1, 10, v);
    chk("R9 rr10 B", v, misc_b);
    rreg(1, 8, v);
    chk("R9 rr8 B", v, rxd_b);
    rreg(0, 5, v);
    chk("R9 rr5 zero", v, 8'h00);
  endtask

  task automatic t_chanrst();
    wreg(1, 5, 8'h66);
    wreg(0, 9, 8'h81);
    chk("R10 chan_rst A", chan_rst, 2'b01);
    chk("R10 A reg5 cleared", slot(cfg_a, 5), 8'h00);
    chk("R10 B reg5 kept", slot(cfg_b, 5), 8'h66);
    chk("R10 vec kept", slot(cfg_a, 2), 8'hA5);
    chk("R10 reg9 stores low", slot(cfg_b, 9), 8'h01);
    wreg(1, 9, 8'h40);
    chk("R10 chan_rst B", chan_rst, 2'b10);
    chk("R10 B reg5 cleared", slot(cfg_b, 5), 8'h00);
    wreg(0, 5, 8'h33);
    sel(0, 7);
    wreg(1, 9, 8'h80);
    ctl_wr(0, 8'h04);
    ctl_wr(0, 8'h12);
    chk("R10 A pointer cleared", slot(cfg_a, 4), 8'h12);
    chk("R10 A reg7 untouched", slot(cfg_a, 7), 8'h00);
    wreg(1, 13, 8'h5E);
    wreg(0, 9, 8'hC0);
    chk("R10 hard chan_rst", chan_rst, 2'b11);
    chk("R10 hard clears", (cfg_a == 0 && cfg_b == 0), 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_data();
    t_point();
    t_ptr_return();
    t_cmd();
    t_crc();
    t_shared();
    t_rr3();
    t_rr2();
    t_rr_misc();
    t_chanrst();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule